// File: doc/BRIEF.md
# Security-State Register Access Filter

This block stands between a register-bus requester and a bank of error-record registers. Every request carries a 2-bit tag naming the security state it was issued from (Root, Secure, Non-secure or Realm). The filter holds one 64-bit access control register and uses it to decide whether each request reaches the downstream bank, whether a read returns real data or zeros, and whether a write takes effect or is dropped. Root requests are never filtered.

The control register holds one 2-bit access level per non-Root state: full read/write, read-only with writes dropped, or no access (reads return zero, writes are dropped). A group status register in the downstream bank stays readable from every state, even one with no access. A build parameter can remove the Secure and Realm levels; the Non-secure level then governs every non-Root state.

Requests use a valid/ready handshake and responses use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the next cycle and is held, unchanged, until `rsp_ready` is high. `req_ready` is low while an earlier response is still waiting, so the block holds at most one outstanding response. The downstream port has no handshake: the bank returns read data in the same cycle as `dn_valid`, and it takes writes on the same edge.

Top module: `sfl_filter`

## Requirements
- R1: Out of reset, `rsp_valid` is 0, `req_ready` is 1, and a read of the control register returns 0x0000_0000_8000_003F.
- R2: A read of the control register (byte address 0xE40) always returns bit 31 as one and bits 63:32 and 30:6 as zero. Writes to those bits have no effect. The register is never forwarded downstream.
- R3: Only a Root-state write changes the control register. Writes to it from any other state leave it unchanged.
- R4: Root-state requests (tag 2'b10) are forwarded downstream whatever the control levels are.
- R5: A level of 2'b00 blocks its state. Reads of gated registers return zero and nothing is forwarded. Writes are not forwarded.
- R6: A level of 2'b01 forwards reads from its state and drops its writes.
- R7: A level of 2'b11 forwards both reads and writes from its state.
- R8: The reserved level 2'b10 behaves exactly like 2'b00.
- R9: A read of the group status register (byte address 0xE00) is forwarded and returns the bank's value from any state, whatever that state's level. Writes to it are gated like any other register.
- R10: Control bits 1:0 govern Non-secure (tag 2'b01), bits 3:2 govern Secure (tag 2'b00) and bits 5:4 govern Realm (tag 2'b11). Each field affects only its own state.
- R11: When the build has no Secure/Realm levels, control bits 5:2 read as zero and ignore writes, and bits 1:0 govern Secure, Non-secure and Realm alike. The reset read value is then 0x0000_0000_8000_0003.
- R12: A response is valid on the cycle after acceptance. It holds stable data while `rsp_ready` is low, and `req_ready` is low during that time. A write's response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sec | input | 2 | Security tag: 00 Secure, 01 Non-secure, 10 Root, 11 Realm |
| req_addr | input | ADDR_W (12) | Byte address in the register window |
| req_wdata | input | DATA_W (64) | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | DATA_W (64) | Read data (zero for writes and blocked reads) |
| dn_valid | output | 1 | Forwarded access strobe to the bank |
| dn_write | output | 1 | Forwarded direction |
| dn_addr | output | ADDR_W (12) | Forwarded address |
| dn_wdata | output | DATA_W (64) | Forwarded write data |
| dn_rdata | input | DATA_W (64) | Bank read data, same cycle as `dn_valid` |

## Verification
A corrupted level field shows up at the ports on the first gated access from the affected state. Either `dn_valid` fires when it should stay low, or the response one cycle later carries bank data where zeros were due. A wrong write-enable on the control register shows up at the next read of it, and also as changed gating for the following accesses. A dropped write that leaks downstream is caught by a later Root read of the same bank word. A lost or duplicated response breaks the order of the expected-response queue on the next handshake.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef enum logic [1:0] {
    SEC_SECURE = 2'b00,
    SEC_NONSEC = 2'b01,
    SEC_ROOT   = 2'b10,
    SEC_REALM  = 2'b11
  } sec_state_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RO   = 2'd1,
    ACC_RW   = 2'd2
  } acc_e;

  localparam int LVL_W       = 2;
  localparam int NUM_LVL     = 3;
  localparam int CTRL_BITS   = LVL_W * NUM_LVL;
  localparam int PRESENT_BIT = 31;

  // 2'b10 is reserved and falls into the no-access case
  function automatic acc_e lvl_decode(input logic [LVL_W-1:0] lvl);
    case (lvl)
      2'b11:   return ACC_RW;
      2'b01:   return ACC_RO;
      default: return ACC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sfl_cfg_reg.sv
module sfl_cfg_reg
  import sfl_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter bit HAS_SR_CTRL = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CTRL_BITS-1:0] wr_lvls,
  output logic [CTRL_BITS-1:0] lvls,
  output logic [DATA_W-1:0]    rd_value
);
  generate
    if (HAS_SR_CTRL) begin : g_full
      logic [CTRL_BITS-1:0] lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     lvl_q <= '1;
        else if (wr_en) lvl_q <= wr_lvls;
      end
      assign lvls = lvl_q;
    end else begin : g_ns_only
      logic [LVL_W-1:0] ns_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ns_q <= '1;
        else if (wr_en) ns_q <= wr_lvls[LVL_W-1:0];
      end
      assign lvls = {{(CTRL_BITS-LVL_W){1'b0}}, ns_q};
      wire unused_hi = ^wr_lvls[CTRL_BITS-1:LVL_W];
    end
  endgenerate

  always_comb begin
    rd_value              = '0;
    rd_value[PRESENT_BIT] = 1'b1;
    rd_value[CTRL_BITS-1:0] = lvls;
  end
endmodule

// File: rtl/sfl_gate.sv
module sfl_gate
  import sfl_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] CFG_OFFSET  = 12'hE40,
  parameter logic [ADDR_W-1:0] GSR_OFFSET  = 12'hE00,
  parameter bit                HAS_SR_CTRL = 1'b1
) (
  input  sec_state_e           sec,
  input  logic                 write,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [CTRL_BITS-1:0] lvls,
  output logic                 hit_cfg,
  output logic                 fwd,
  output logic                 cfg_wr_ok
);
  logic [LVL_W-1:0] sel_lvl;
  acc_e             acc;
  logic             allow;
  logic             hit_gsr;
  logic             is_root;

  generate
    if (HAS_SR_CTRL) begin : g_per_state
      always_comb begin
        case (sec)
          SEC_SECURE: sel_lvl = lvls[2*LVL_W-1:LVL_W];
          SEC_REALM:  sel_lvl = lvls[3*LVL_W-1:2*LVL_W];
          default:    sel_lvl = lvls[LVL_W-1:0];
        endcase
      end
    end else begin : g_shared
      assign sel_lvl = lvls[LVL_W-1:0];
      wire unused_sr = ^lvls[CTRL_BITS-1:LVL_W];
    end
  endgenerate

  always_comb begin
    is_root   = (sec == SEC_ROOT);
    acc       = lvl_decode(sel_lvl);
    allow     = is_root || (acc == ACC_RW) || ((acc == ACC_RO) && !write);
    hit_cfg   = (addr == CFG_OFFSET);
    hit_gsr   = (addr == GSR_OFFSET);
    fwd       = !hit_cfg && (allow || (hit_gsr && !write));
    cfg_wr_ok = hit_cfg && write && is_root;
  end
endmodule

// File: rtl/sfl_rsp.sv
module sfl_rsp #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              free
);
  assign free = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sfl_filter.sv
module sfl_filter
  import sfl_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter int                DATA_W      = 64,
  parameter logic [ADDR_W-1:0] CFG_OFFSET  = 12'hE40,
  parameter logic [ADDR_W-1:0] GSR_OFFSET  = 12'hE00,
  parameter bit                HAS_SR_CTRL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_sec,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dn_valid,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic [DATA_W-1:0] dn_rdata
);
  logic [CTRL_BITS-1:0] ctrl_q;
  logic [DATA_W-1:0]    cfg_value;
  logic [DATA_W-1:0]    rsp_data;
  logic                 accept;
  logic                 hit_cfg;
  logic                 fwd;
  logic                 cfg_wr_ok;

  assign accept = req_valid && req_ready;

  sfl_gate #(
    .ADDR_W(ADDR_W), .CFG_OFFSET(CFG_OFFSET),
    .GSR_OFFSET(GSR_OFFSET), .HAS_SR_CTRL(HAS_SR_CTRL)
  ) gate_i (
    .sec(sec_state_e'(req_sec)), .write(req_write), .addr(req_addr),
    .lvls(ctrl_q), .hit_cfg(hit_cfg), .fwd(fwd), .cfg_wr_ok(cfg_wr_ok)
  );

  sfl_cfg_reg #(.DATA_W(DATA_W), .HAS_SR_CTRL(HAS_SR_CTRL)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(accept && cfg_wr_ok),
    .wr_lvls(req_wdata[CTRL_BITS-1:0]), .lvls(ctrl_q), .rd_value(cfg_value)
  );

  always_comb begin
    if (req_write)    rsp_data = '0;
    else if (hit_cfg) rsp_data = cfg_value;
    else if (fwd)     rsp_data = dn_rdata;
    else              rsp_data = '0;
  end

  sfl_rsp #(.DATA_W(DATA_W)) rsp_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(rsp_data),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .free(req_ready)
  );

  assign dn_valid = accept && fwd;
  assign dn_write = req_write;
  assign dn_addr  = req_addr;
  assign dn_wdata = req_wdata;
endmodule

// File: rtl/sfl_chk.sv
module sfl_chk
  import sfl_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter int                DATA_W     = 64,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = 12'hE40,
  parameter logic [ADDR_W-1:0] GSR_OFFSET = 12'hE00
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic [1:0]           req_sec,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [DATA_W-1:0]    rsp_rdata,
  input logic                 dn_valid,
  input logic                 dn_write,
  input logic [CTRL_BITS-1:0] ctrl_q
);
  logic acc;
  logic other_addr;
  assign acc        = req_valid && req_ready;
  assign other_addr = (req_addr != CFG_OFFSET) && (req_addr != GSR_OFFSET);

  assert_rsp_next_R12: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_stall_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_cfg_fmt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_addr == CFG_OFFSET) |=>
      (rsp_rdata[31] && rsp_rdata[63:32] == '0 && rsp_rdata[30:6] == '0));

  assert_cfg_never_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr == CFG_OFFSET) |-> !dn_valid);

  assert_cfg_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_addr == CFG_OFFSET && req_sec != 2'b10) |=> $stable(ctrl_q));

  assert_root_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_sec == 2'b10 && req_addr != CFG_OFFSET) |-> dn_valid);

  // covers R8 as well: reserved 2'b10 in the Non-secure field must also block
  assert_ns_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_sec == 2'b01 && other_addr && !ctrl_q[0]) |-> !dn_valid);

  assert_ns_ro_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_sec == 2'b01 && ctrl_q[1:0] == 2'b01 && req_write) |-> !dn_valid);

  assert_gsr_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_addr == GSR_OFFSET) |-> (dn_valid && !dn_write));

  assert_dn_only_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> acc);
endmodule

bind sfl_filter sfl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CFG_OFFSET(CFG_OFFSET), .GSR_OFFSET(GSR_OFFSET)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_sec(req_sec), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .dn_valid(dn_valid), .dn_write(dn_write), .ctrl_q(ctrl_q)
);

// File: tb/sfl_filter_tb_top.sv
module sfl_filter_tb_top;
  localparam logic [11:0] CFG = 12'hE40;
  localparam logic [11:0] GSR = 12'hE00;
  localparam logic [63:0] GSR_VAL = 64'h5157_A5A5_0000_00C3;
  localparam logic [63:0] BANK2_VAL = 64'h0BAD_F00D_1234_5678;
  localparam logic [1:0] S_SEC = 2'b00, S_NS = 2'b01, S_ROOT = 2'b10, S_RL = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 1'b0, req_valid2 = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0]  req_sec = 2'b00;
  logic [11:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, dn_valid, dn_write;
  logic [11:0] dn_addr;
  logic [63:0] rsp_rdata, dn_wdata, dn_rdata;
  logic req_ready2, rsp_valid2, dn_valid2, dn_write2;
  logic [11:0] dn_addr2;
  logic [63:0] rsp_rdata2, dn_wdata2;

  logic [63:0] bank [16];
  always_comb dn_rdata = (dn_addr == GSR) ? GSR_VAL : bank[dn_addr[6:3]];

  sfl_filter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sec(req_sec), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_rdata(dn_rdata));

  sfl_filter #(.HAS_SR_CTRL(1'b0)) dut_ns_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid2), .req_ready(req_ready2),
    .req_write(req_write), .req_sec(req_sec), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid2), .rsp_ready(1'b1), .rsp_rdata(rsp_rdata2),
    .dn_valid(dn_valid2), .dn_write(dn_write2), .dn_addr(dn_addr2), .dn_wdata(dn_wdata2),
    .dn_rdata(BANK2_VAL));

  int total = 0, bad = 0, dn_wr_cnt = 0, dn2_wr_cnt = 0;
  always @(posedge clk) begin
    if (dn_valid && dn_write) begin
      dn_wr_cnt++;
      if (dn_addr != GSR) bank[dn_addr[6:3]] <= dn_wdata;
    end
    if (dn_valid2 && dn_write2) dn2_wr_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { logic [63:0] data; string tag; } exp_t;
  exp_t exp_q[$];
  logic [5:0]  m_ctrl;
  logic [63:0] m_bank [16];

  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R12 unexpected response", rsp_rdata, '0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e.data, e.tag, rsp_rdata, e.data);
      end
    end
  end

  function automatic bit m_allow(input logic [1:0] sec, input bit wr);
    logic [1:0] lvl;
    if (sec == S_ROOT) return 1'b1;
    lvl = (sec == S_SEC) ? m_ctrl[3:2] : (sec == S_RL) ? m_ctrl[5:4] : m_ctrl[1:0];
    return (lvl == 2'b11) || (lvl == 2'b01 && !wr);
  endfunction

  int exp_dn_wr = 0;
  task automatic xfer(input logic [1:0] sec, input bit wr, input logic [11:0] addr,
                      input logic [63:0] wdata, input string tag);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    e.tag = tag;
    e.data = '0;
    if (addr == CFG) begin
      if (!wr) e.data = {32'h0, 1'b1, 25'h0, m_ctrl};
      else if (sec == S_ROOT) m_ctrl = wdata[5:0];
    end else if (addr == GSR && !wr) begin
      e.data = GSR_VAL;
    end else if (m_allow(sec, wr)) begin
      if (wr) begin
        exp_dn_wr++;
        if (addr != GSR) m_bank[addr[6:3]] = wdata;
      end else e.data = m_bank[addr[6:3]];
    end
    exp_q.push_back(e);
    req_valid = 1'b1; req_sec = sec; req_write = wr; req_addr = addr; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic xfer2(input logic [1:0] sec, input bit wr, input logic [11:0] addr,
                       input logic [63:0] wdata, input logic [63:0] exp, input string tag);
    @(negedge clk);
    req_valid2 = 1'b1; req_sec = sec; req_write = wr; req_addr = addr; req_wdata = wdata;
    @(negedge clk);
    req_valid2 = 1'b0;
    chk(rsp_valid2 && rsp_rdata2 == exp, tag, rsp_rdata2, exp);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", '0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      bank[i] = 64'hC0DE_0000_0000_0000 | 64'(i * 17 + 3);
      m_bank[i] = bank[i];
    end
    m_ctrl = 6'h3F;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && req_ready, "R1 reset handshake", {62'h0, rsp_valid, req_ready}, 64'h1);
    rst_n = 1'b1;
    // R1 R2: reset value
    xfer(S_NS, 1'b0, CFG, '0, "R1 reset cfg read");
    // R7: full access at reset
    xfer(S_NS, 1'b0, 12'h010, '0, "R7 ns read");
    xfer(S_NS, 1'b1, 12'h010, 64'h1111_2222_3333_4444, "R7 ns write rsp");
    xfer(S_NS, 1'b0, 12'h010, '0, "R7 ns readback");
    // R2 R10: Root sets NS=01, S=00, RL=11 with junk in reserved bits
    xfer(S_ROOT, 1'b1, CFG, 64'hFFFF_FFFF_FFFF_FFF1, "R2 cfg write rsp");
    xfer(S_SEC, 1'b0, CFG, '0, "R2 cfg format");
    // R3: non-root writes to cfg ignored
    xfer(S_NS, 1'b1, CFG, 64'h0, "R3 ns cfg write");
    xfer(S_RL, 1'b1, CFG, 64'h0, "R3 realm cfg write");
    xfer(S_ROOT, 1'b0, CFG, '0, "R3 cfg unchanged");
    // R6: NS read-only
    xfer(S_NS, 1'b0, 12'h020, '0, "R6 ns read passes");
    xfer(S_NS, 1'b1, 12'h020, 64'hDEAD_DEAD_DEAD_DEAD, "R6 ns write rsp");
    xfer(S_ROOT, 1'b0, 12'h020, '0, "R6 ns write dropped");
    // R5 R10: Secure blocked
    xfer(S_SEC, 1'b0, 12'h028, '0, "R5 sec read zero");
    xfer(S_SEC, 1'b1, 12'h028, 64'hBEEF, "R5 sec write rsp");
    xfer(S_ROOT, 1'b0, 12'h028, '0, "R5 sec write dropped");
    // R9: group status from blocked state
    xfer(S_SEC, 1'b0, GSR, '0, "R9 gsr read blocked sec");
    // R7 R10: Realm full
    xfer(S_RL, 1'b1, 12'h030, 64'h7777_0000_0000_0001, "R10 realm write rsp");
    xfer(S_RL, 1'b0, 12'h030, '0, "R10 realm readback");
    // R4: all blocked, Root still passes
    xfer(S_ROOT, 1'b1, CFG, 64'h0, "R4 cfg clear");
    xfer(S_ROOT, 1'b1, 12'h038, 64'h0123_4567_89AB_CDEF, "R4 root write rsp");
    xfer(S_ROOT, 1'b0, 12'h038, '0, "R4 root read");
    xfer(S_RL, 1'b0, GSR, '0, "R9 gsr read blocked realm");
    // R8: reserved 10 blocks
    xfer(S_ROOT, 1'b1, CFG, 64'h2A, "R8 cfg set reserved");
    xfer(S_NS, 1'b0, 12'h038, '0, "R8 ns read zero");
    xfer(S_RL, 1'b1, 12'h038, 64'h55, "R8 realm write rsp");
    xfer(S_ROOT, 1'b0, 12'h038, '0, "R8 write dropped");
    drain();
    chk(dn_wr_cnt == exp_dn_wr, "R5 forwarded write count", 64'(dn_wr_cnt), 64'(exp_dn_wr));

    // R12: back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    xfer(S_ROOT, 1'b0, 12'h010, '0, "R12 stalled read");
    repeat (2) @(negedge clk);
    chk(rsp_valid && !req_ready && rsp_rdata == m_bank[2], "R12 held response",
        rsp_rdata, m_bank[2]);
    @(posedge clk); #1 rsp_ready = 1'b1;
    drain();

    // R11: build without Secure/Realm levels
    xfer2(S_NS, 1'b0, CFG, '0, 64'h0000_0000_8000_0003, "R11 reset cfg");
    xfer2(S_ROOT, 1'b1, CFG, 64'h3D, '0, "R11 cfg write");
    xfer2(S_SEC, 1'b0, CFG, '0, 64'h0000_0000_8000_0001, "R11 upper bits zero");
    xfer2(S_SEC, 1'b0, 12'h008, '0, BANK2_VAL, "R11 sec read via ns level");
    xfer2(S_RL, 1'b1, 12'h008, 64'h9, '0, "R11 realm write");
    chk(dn2_wr_cnt == 0, "R11 realm write dropped", 64'(dn2_wr_cnt), 64'h0);
    xfer2(S_ROOT, 1'b1, CFG, 64'h3C, '0, "R11 cfg ns off");
    xfer2(S_RL, 1'b0, 12'h008, '0, '0, "R11 realm read zero");
    xfer2(S_SEC, 1'b0, GSR, '0, BANK2_VAL, "R11 gsr read");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule